// File: doc/BRIEF.md
# Desaturation Monitor with Two-Stage Gate Drive

This block controls one power switch of an inverter bridge. It takes a synchronised on/off command and drives four stage enables. A main sourcing stage stays on for the whole conduction interval. A boost sourcing stage helps only during the first cycles after turn-on. A sink stage holds the gate low while the switch is off. A soft pull-down path is used only while a controlled shutdown is running. All time intervals are parameters counted in clock cycles.

A digital comparator input reports whether the switch's sensed collector voltage is above the desaturation threshold. The block ignores this input while the switch is commanded off. It also ignores it during a blanking window that restarts at every turn-on. Outside those times, the comparator must stay high for a programmed number of consecutive cycles before the block counts it as a desaturation. The block then sends one single-cycle flag to the bridge-level fault coordinator and keeps driving until the coordinator commands a soft shutdown. After the soft pull-down interval the gate is held hard off until the on command is released.

The same comparator also feeds a voltage-feedback status output. This output reports the switch as conducting while the sensed voltage is below the threshold. It passes through a persistence counter, so any level it reports lasts at least a minimum number of cycles.

Top module: `desat_gate_channel`

## Requirements
- R1: While reset is held and directly after it, `sink_en` is 1 and `src_main_en`, `src_boost_en`, `ssd_pd_en`, `desat_flag` and `vfb_on` are 0.
- R2: The cycle after `on_cmd` is sampled high from the off state, `src_main_en` is 1 and `sink_en` is 0. The cycle after `on_cmd` is sampled low in the on state, `sink_en` is 1 and `src_main_en` is 0. At all times exactly one of `src_main_en`, `sink_en`, `ssd_pd_en` is 1.
- R3: `src_boost_en` is 1 for exactly BOOST_CYC cycles, starting in the first cycle `src_main_en` is 1, and is never 1 without `src_main_en`.
- R4: For BLANK_CYC cycles after each turn-on, `desat_cmp` is not counted. Turning off during that window abandons it, and the next turn-on starts a full new window.
- R5: `desat_flag` rises only after `desat_cmp` has been sampled high in FILT_CYC consecutive unblanked on cycles. A shorter high run resets the count.
- R6: `desat_flag` is a single-cycle pulse, issued once per uninterrupted desaturation run. With `desat_cmp` held high from turn-on, it is 1 in the cycle that follows BLANK_CYC+FILT_CYC+1 rising clock edges after `on_cmd` is raised.
- R7: While the switch is off, `desat_cmp` never produces `desat_flag`.
- R8: `ssd_cmd` sampled high in the on state releases both the sourcing stages and the sink. `ssd_pd_en` then stays 1 for exactly SSD_CYC cycles, and after that `sink_en` is 1. During the pull-down, `on_cmd` and further `ssd_cmd` have no effect. After it, the gate stays off until `on_cmd` has been sampled low.
- R9: `ssd_cmd` sampled while the switch is off has no effect. A later turn-on proceeds normally.
- R10: `vfb_on` is 1 when `desat_cmp` is 0 and 0 when `desat_cmp` is 1. A change in `desat_cmp` reaches `vfb_on` only after the new level has been sampled on VFB_MIN_CYC consecutive edges, so shorter runs are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_cmd | input | 1 | Synchronised switch on (1) / off (0) command |
| desat_cmp | input | 1 | Comparator: 1 = sensed voltage above desaturation threshold |
| ssd_cmd | input | 1 | Soft-shutdown command from the fault coordinator |
| src_main_en | output | 1 | Main sourcing stage enable |
| src_boost_en | output | 1 | Time-limited boost sourcing stage enable |
| sink_en | output | 1 | Normal turn-off sink enable |
| ssd_pd_en | output | 1 | Soft-shutdown pull-down enable |
| desat_flag | output | 1 | Single-cycle desaturation event pulse |
| vfb_on | output | 1 | Filtered voltage-feedback status, 1 = switch conducting |

## Verification
The assertions check several properties on every cycle. Exactly one gate stage is enabled at a time. The boost window is measured against an independent conduction counter. The soft pull-down length and what follows it are checked. The flag must be a one-cycle pulse, must come from an unblanked on cycle, and must not fire while the switch is off. Every feedback edge must agree with the comparator level. Only the bench's scenarios can show the exact cycle counts from command to flag: blanking restart after an aborted turn-on, rejection of a filter run one cycle short, the lock-out that persists until the command drops, and rejection of short feedback glitches.

// File: rtl/desat_gate_pkg.sv
package desat_gate_pkg;

  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_ON   = 2'd1,
    DRV_SSD  = 2'd2,
    DRV_LOCK = 2'd3
  } drv_state_e;

  // Counter width able to hold the value lim.
  function automatic int cnt_w(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // A window of lim cycles, indexed from zero, is still open at count cnt.
  function automatic logic window_open(int unsigned cnt, int unsigned lim);
    return cnt < lim;
  endfunction

  // Persistence counter reaches its limit on this sample.
  function automatic logic run_complete(int unsigned cnt, int unsigned lim);
    return cnt == lim - 1;
  endfunction

endpackage

// File: rtl/dg_drive_seq.sv
module dg_drive_seq
  import desat_gate_pkg::*;
#(
  parameter int unsigned BOOST_CYC = 13,
  parameter int unsigned SSD_CYC   = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_cmd,
  input  logic ssd_cmd,
  output logic src_main_en,
  output logic src_boost_en,
  output logic sink_en,
  output logic ssd_pd_en,
  output logic on_active
);

  localparam int unsigned CNT_LIM = (SSD_CYC > BOOST_CYC) ? SSD_CYC : BOOST_CYC;
  localparam int CW = cnt_w(CNT_LIM);

  drv_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      DRV_OFF: begin
        if (on_cmd) begin
          state_d = DRV_ON;
          cnt_d   = '0;
        end
      end
      DRV_ON: begin
        if (ssd_cmd) begin
          state_d = DRV_SSD;
          cnt_d   = '0;
        end else if (!on_cmd) begin
          state_d = DRV_OFF;
        end else if (cnt_q < CW'(BOOST_CYC)) begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      DRV_SSD: begin
        if (run_complete(32'(cnt_q), SSD_CYC)) begin
          state_d = DRV_LOCK;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      DRV_LOCK: begin
        if (!on_cmd) state_d = DRV_OFF;
      end
      default: state_d = DRV_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DRV_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign on_active    = (state_q == DRV_ON);
  assign src_main_en  = on_active;
  assign src_boost_en = on_active && window_open(32'(cnt_q), BOOST_CYC);
  assign ssd_pd_en    = (state_q == DRV_SSD);
  assign sink_en      = (state_q == DRV_OFF) || (state_q == DRV_LOCK);

endmodule

// File: rtl/dg_desat_det.sv
module dg_desat_det
  import desat_gate_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 225,
  parameter int unsigned FILT_CYC  = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_active,
  input  logic desat_cmp,
  output logic blank_win,
  output logic desat_flag
);

  localparam int BW = cnt_w(BLANK_CYC);
  localparam int FW = cnt_w(FILT_CYC);

  logic [BW-1:0] blank_q;
  logic [FW-1:0] filt_q;
  logic          qualify;
  logic          flag_q;

  // Blanking restarts each time the switch enters the on state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '0;
    end else if (!on_active) begin
      blank_q <= '0;
    end else if (blank_q < BW'(BLANK_CYC)) begin
      blank_q <= blank_q + BW'(1);
    end
  end

  assign blank_win = on_active && window_open(32'(blank_q), BLANK_CYC);
  assign qualify   = on_active && !blank_win && desat_cmp;

  // Consecutive-sample filter; saturates so that one run gives one flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= qualify && run_complete(32'(filt_q), FILT_CYC);
      if (!qualify) begin
        filt_q <= '0;
      end else if (filt_q < FW'(FILT_CYC)) begin
        filt_q <= filt_q + FW'(1);
      end
    end
  end

  assign desat_flag = flag_q;

endmodule

// File: rtl/dg_vfb_filter.sv
module dg_vfb_filter
  import desat_gate_pkg::*;
#(
  parameter int unsigned MIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic desat_cmp,
  output logic vfb_on
);

  localparam int VW = cnt_w(MIN_CYC);

  logic          raw_on;
  logic          out_q;
  logic [VW-1:0] run_q;

  assign raw_on = !desat_cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      run_q <= '0;
    end else if (raw_on != out_q) begin
      if (run_complete(32'(run_q), MIN_CYC)) begin
        out_q <= raw_on;
        run_q <= '0;
      end else begin
        run_q <= run_q + VW'(1);
      end
    end else begin
      run_q <= '0;
    end
  end

  assign vfb_on = out_q;

endmodule

// File: rtl/desat_gate_channel.sv
module desat_gate_channel #(
  parameter int unsigned BLANK_CYC   = 225,
  parameter int unsigned FILT_CYC    = 150,
  parameter int unsigned BOOST_CYC   = 13,
  parameter int unsigned SSD_CYC     = 300,
  parameter int unsigned VFB_MIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_cmd,
  input  logic desat_cmp,
  input  logic ssd_cmd,
  output logic src_main_en,
  output logic src_boost_en,
  output logic sink_en,
  output logic ssd_pd_en,
  output logic desat_flag,
  output logic vfb_on
);

  logic on_active;
  logic blank_win;

  dg_drive_seq #(
    .BOOST_CYC (BOOST_CYC),
    .SSD_CYC   (SSD_CYC)
  ) u_drive (
    .clk          (clk),
    .rst_n        (rst_n),
    .on_cmd       (on_cmd),
    .ssd_cmd      (ssd_cmd),
    .src_main_en  (src_main_en),
    .src_boost_en (src_boost_en),
    .sink_en      (sink_en),
    .ssd_pd_en    (ssd_pd_en),
    .on_active    (on_active)
  );

  dg_desat_det #(
    .BLANK_CYC (BLANK_CYC),
    .FILT_CYC  (FILT_CYC)
  ) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_active  (on_active),
    .desat_cmp  (desat_cmp),
    .blank_win  (blank_win),
    .desat_flag (desat_flag)
  );

  dg_vfb_filter #(
    .MIN_CYC (VFB_MIN_CYC)
  ) u_vfb (
    .clk       (clk),
    .rst_n     (rst_n),
    .desat_cmp (desat_cmp),
    .vfb_on    (vfb_on)
  );

endmodule

// File: rtl/desat_gate_channel_chk.sv
module desat_gate_channel_chk #(
  parameter int unsigned BOOST_CYC = 13,
  parameter int unsigned SSD_CYC   = 300
) (
  input logic clk,
  input logic rst_n,
  input logic desat_cmp,
  input logic ssd_cmd,
  input logic src_main_en,
  input logic src_boost_en,
  input logic sink_en,
  input logic ssd_pd_en,
  input logic desat_flag,
  input logic vfb_on,
  input logic blank_win
);

  logic [31:0] on_len;
  logic [31:0] ssd_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_len  <= '0;
      ssd_len <= '0;
    end else begin
      if (!src_main_en)            on_len <= '0;
      else if (on_len <= BOOST_CYC) on_len <= on_len + 32'd1;
      if (!ssd_pd_en)              ssd_len <= '0;
      else                         ssd_len <= ssd_len + 32'd1;
    end
  end

  a_r2_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({src_main_en, sink_en, ssd_pd_en}) == 1);

  a_r3_boost_window: assert property (@(posedge clk) disable iff (!rst_n)
    src_main_en |-> (src_boost_en == (on_len < BOOST_CYC)));

  a_r3_boost_needs_main: assert property (@(posedge clk) disable iff (!rst_n)
    src_boost_en |-> src_main_en);

  a_r4_flag_after_blank: assert property (@(posedge clk) disable iff (!rst_n)
    desat_flag |-> !$past(blank_win));

  a_r6_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    desat_flag |=> !desat_flag);

  a_r7_flag_only_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    desat_flag |-> $past(src_main_en));

  a_r8_ssd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssd_pd_en) |-> ($past(ssd_cmd) && $past(src_main_en)));

  a_r8_ssd_length: assert property (@(posedge clk) disable iff (!rst_n)
    ssd_pd_en |-> (ssd_len < SSD_CYC));

  a_r8_ssd_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssd_pd_en) |-> (sink_en && ($past(ssd_len) == SSD_CYC - 1)));

  a_r10_vfb_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vfb_on) |-> !$past(desat_cmp));

  a_r10_vfb_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vfb_on) |-> $past(desat_cmp));

endmodule

bind desat_gate_channel desat_gate_channel_chk #(
  .BOOST_CYC (BOOST_CYC),
  .SSD_CYC   (SSD_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .desat_cmp    (desat_cmp),
  .ssd_cmd      (ssd_cmd),
  .src_main_en  (src_main_en),
  .src_boost_en (src_boost_en),
  .sink_en      (sink_en),
  .ssd_pd_en    (ssd_pd_en),
  .desat_flag   (desat_flag),
  .vfb_on       (vfb_on),
  .blank_win    (blank_win)
);

// File: tb/tb_desat_gate_channel.sv
module tb_desat_gate_channel;

  localparam int BLANK = 225;
  localparam int FILT  = 150;
  localparam int BOOST = 13;
  localparam int SSD   = 300;
  localparam int VFB   = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic on_cmd, desat_cmp, ssd_cmd;
  logic src_main_en, src_boost_en, sink_en, ssd_pd_en, desat_flag, vfb_on;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  desat_gate_channel #(
    .BLANK_CYC   (BLANK),
    .FILT_CYC    (FILT),
    .BOOST_CYC   (BOOST),
    .SSD_CYC     (SSD),
    .VFB_MIN_CYC (VFB)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .on_cmd       (on_cmd),
    .desat_cmp    (desat_cmp),
    .ssd_cmd      (ssd_cmd),
    .src_main_en  (src_main_en),
    .src_boost_en (src_boost_en),
    .sink_en      (sink_en),
    .ssd_pd_en    (ssd_pd_en),
    .desat_flag   (desat_flag),
    .vfb_on       (vfb_on)
  );

  // Advance n rising edges, then settle 2 ns past the edge.
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Gate stage vector {main, boost, sink, pd}.
  task automatic chk_gate(input string req, input logic [3:0] exp);
    checks++;
    if ({src_main_en, src_boost_en, sink_en, ssd_pd_en} !== exp) begin
      errors++;
      $display("FAIL %s gate stages: actual %b expected %b", req,
               {src_main_en, src_boost_en, sink_en, ssd_pd_en}, exp);
    end
  endtask

  // Step n edges and require no flag after any of them.
  task automatic quiet_flag(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (desat_flag) seen++;
    end
    chk(req, "no flag in window", seen != 0, 1'b0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; on_cmd = 1'b0; desat_cmp = 1'b1; ssd_cmd = 1'b0;
    step(3);
    chk_gate("R1", 4'b0010);
    chk("R1", "flag in reset", desat_flag, 1'b0);
    chk("R1", "vfb in reset", vfb_on, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk_gate("R1", 4'b0010);
    chk("R1", "vfb after reset", vfb_on, 1'b0);
  endtask

  task automatic t_turn_on_boost;
    on_cmd = 1'b1;
    step(1);
    chk_gate("R2", 4'b1100);
    step(BOOST - 1);
    chk("R3", "boost last cycle", src_boost_en, 1'b1);
    step(1);
    chk_gate("R3", 4'b1000);
    on_cmd = 1'b0;
    step(1);
    chk_gate("R2", 4'b0010);
  endtask

  task automatic t_flag_timing;
    desat_cmp = 1'b1;
    on_cmd = 1'b1;
    quiet_flag("R4", BLANK + FILT);
    step(1);
    chk("R6", "flag at blank+filter", desat_flag, 1'b1);
    step(1);
    chk("R6", "flag single cycle", desat_flag, 1'b0);
    quiet_flag("R6", 40);
    chk("R6", "still driving after flag", src_main_en, 1'b1);
    on_cmd = 1'b0;
    step(2);
  endtask

  task automatic t_filter_short;
    desat_cmp = 1'b0;
    on_cmd = 1'b1;
    step(BLANK + 5);
    desat_cmp = 1'b1;
    quiet_flag("R5", FILT - 1);
    desat_cmp = 1'b0;
    quiet_flag("R5", 5);
    desat_cmp = 1'b1;
    quiet_flag("R5", FILT - 1);
    step(1);
    chk("R5", "flag after full run", desat_flag, 1'b1);
    desat_cmp = 1'b1;
    on_cmd = 1'b0;
    step(2);
  endtask

  task automatic t_blank_abort;
    desat_cmp = 1'b1;
    on_cmd = 1'b1;
    step(BLANK / 2);
    on_cmd = 1'b0;
    step(2);
    on_cmd = 1'b1;
    quiet_flag("R4", BLANK + FILT);
    step(1);
    chk("R4", "flag after restarted blanking", desat_flag, 1'b1);
    on_cmd = 1'b0;
    step(2);
  endtask

  task automatic t_off_ignored;
    on_cmd = 1'b0;
    desat_cmp = 1'b1;
    quiet_flag("R7", 2 * (BLANK + FILT));
    chk_gate("R7", 4'b0010);
  endtask

  task automatic t_ssd;
    desat_cmp = 1'b1;
    on_cmd = 1'b1;
    step(BLANK + FILT + 1);
    chk("R8", "flag before shutdown", desat_flag, 1'b1);
    ssd_cmd = 1'b1;
    step(1);
    ssd_cmd = 1'b0;
    chk_gate("R8", 4'b0001);
    step(10);
    ssd_cmd = 1'b1;
    on_cmd = 1'b0;
    step(1);
    ssd_cmd = 1'b0;
    on_cmd = 1'b1;
    chk_gate("R8", 4'b0001);
    step(SSD - 12);
    chk("R8", "pull-down last cycle", ssd_pd_en, 1'b1);
    step(1);
    chk_gate("R8", 4'b0010);
    step(10);
    chk_gate("R8", 4'b0010);
    on_cmd = 1'b0;
    step(1);
    chk_gate("R8", 4'b0010);
    on_cmd = 1'b1;
    step(1);
    chk_gate("R8", 4'b1100);
    on_cmd = 1'b0;
    step(2);
  endtask

  task automatic t_ssd_when_off;
    on_cmd = 1'b0;
    ssd_cmd = 1'b1;
    step(1);
    ssd_cmd = 1'b0;
    chk_gate("R9", 4'b0010);
    on_cmd = 1'b1;
    step(1);
    chk_gate("R9", 4'b1100);
    on_cmd = 1'b0;
    step(2);
  endtask

  task automatic t_vfb;
    desat_cmp = 1'b1;
    step(VFB + 2);
    chk("R10", "vfb off while above threshold", vfb_on, 1'b0);
    desat_cmp = 1'b0;
    step(VFB - 1);
    chk("R10", "vfb before persistence", vfb_on, 1'b0);
    step(1);
    chk("R10", "vfb on after persistence", vfb_on, 1'b1);
    desat_cmp = 1'b1;
    step(VFB - 1);
    desat_cmp = 1'b0;
    step(VFB);
    chk("R10", "short high glitch dropped", vfb_on, 1'b1);
    desat_cmp = 1'b1;
    step(VFB);
    chk("R10", "vfb off after persistence", vfb_on, 1'b0);
  endtask

  initial begin
    t_reset();
    t_turn_on_boost();
    t_flag_timing();
    t_filter_short();
    t_blank_abort();
    t_off_ignored();
    t_ssd();
    t_ssd_when_off();
    t_vfb();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule